// File: doc/BRIEF.md
# Two-Word-Cell Stack Operation Unit

This block executes three stack opcodes on an operand stack that lives in word-addressed memory. Every stack element is a cell of two 16-bit words: the high word sits at the lower address and the low word at the address above it. The unit holds the top-of-stack pointer, which always addresses the low word of the top cell. It also holds a free-space counter that gives the number of cells that may still be pushed. All memory traffic goes through one port that takes one fetch or one store request per cycle. Fetched data returns on the cycle after the request.

An instruction-fetch stage presents an opcode with a valid strobe. The unit takes the opcode only while it signals ready. It stays busy (not ready) until the opcode's sequence ends, then gives a one-cycle done pulse. POP changes only the pointer and the counter. COPY fetches the top cell and stores an identical cell above it, unless the counter is zero; in that case it raises a one-cycle overflow error and touches nothing. SWAP fetches both cells into holding registers and writes them back in exchanged order.

The controller states are: IDLE (waiting, ready), POP (pointer and counter update), CP_RHI / CP_RLO (fetch high then low word of the top cell), CP_WHI / CP_WLO (store the duplicate), SW_RBH / SW_RBL / SW_RAH / SW_RAL (fetch B-high, B-low, A-high, A-low) and SW_W0 to SW_W3 (four stores). Transitions: IDLE goes to POP, CP_RHI or SW_RBH on an accepted opcode. IDLE stays in IDLE on an overflowing COPY or an unknown code. Each multi-cycle state moves to the next in the order above. POP, CP_WLO and SW_W3 return to IDLE and raise done.

Top module: `stkop_unit`

## Requirements
- R1: After reset the unit is ready, done, ovf_err and mem_req are low, tos equals TOS_RESET and free_cells equals FREE_RESET.
- R2: An opcode is taken only on a clock edge where op_valid and op_ready are both high. op_ready is low from the edge that takes a multi-cycle opcode until its done pulse. An opcode outside the three known codes has no effect: no memory access, no done, no change of tos or free_cells.
- R3: POP lowers tos by 2, raises free_cells by 1, issues no memory access, and pulses done on the cycle after the edge that takes it.
- R4: COPY with free_cells nonzero fetches tos-1 then tos. It then stores the fetched high word at tos+1 and the low word at tos+2, raises tos by 2 and lowers free_cells by 1. Done follows four cycles after the edge that takes it.
- R5: COPY with free_cells zero makes no memory access and leaves tos and free_cells unchanged. It pulses ovf_err (and not done) on the cycle after the edge that takes it.
- R6: SWAP with top cell B and the cell A below it fetches tos-1, tos, tos-3, tos-2 in that order. It then stores B-high at tos-3, B-low at tos-2, A-high at tos-1 and A-low at tos, in that order. tos and free_cells stay unchanged, and done follows eight cycles after the edge that takes it.
- R7: At most one memory request is issued per cycle. Fetched data is taken from mem_rdata on the cycle after the fetch, and no request is issued while idle.
- R8: Opcode encodings on op_code[7:0]: COPY = 8'h64 (octal 144), POP = 8'hBF (octal 277), SWAP = 8'hFD (octal 375).
- R9: done is a single-cycle pulse, given exactly once per completed POP, COPY or SWAP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Opcode on op_code is valid |
| op_code | input | 8 | Opcode from the fetch stage |
| op_ready | output | 1 | Unit idle, may take an opcode |
| done | output | 1 | One-cycle pulse when an opcode completes |
| ovf_err | output | 1 | One-cycle pulse when a COPY finds no free space |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a store (1) or fetch (0) |
| mem_addr | output | AW | Word address of the request |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Fetch data, valid the cycle after the fetch |
| tos | output | AW | Address of the low word of the top cell |
| free_cells | output | CW | Cells that may still be pushed |

## Verification
Stimulus starts with SWAP on a preloaded stack whose every word is distinct. This shows whether the four fetches and four stores go to the right addresses in the right order and whether high and low words are paired correctly. Two COPYs then fill the free space and a third COPY meets a zero counter. This separates a correct push from one that is off by a word and shows that the overflow path issues no access. An unknown code, two POPs back to back, and a second SWAP and COPY on the moved pointer show that ignored opcodes leave the state alone and that sequences chain without a lost or doubled done. While the unit is busy the driver holds op_valid high with another code, so any acceptance outside ready would show up as an extra access or result.

// File: rtl/stkop_pkg.sv
package stkop_pkg;

    localparam int WORD_W = 16;

    localparam logic [7:0] OPC_COPY = 8'h64;
    localparam logic [7:0] OPC_POP  = 8'hBF;
    localparam logic [7:0] OPC_SWAP = 8'hFD;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POP,
        ST_CP_RHI,
        ST_CP_RLO,
        ST_CP_WHI,
        ST_CP_WLO,
        ST_SW_RBH,
        ST_SW_RBL,
        ST_SW_RAH,
        ST_SW_RAL,
        ST_SW_W0,
        ST_SW_W1,
        ST_SW_W2,
        ST_SW_W3
    } stk_state_e;

endpackage

// File: rtl/stkop_agen.sv
module stkop_agen
    import stkop_pkg::*;
#(
    parameter int AW = 16
) (
    input  stk_state_e      state,
    input  logic [AW-1:0]   tos,
    output logic            req,
    output logic            we,
    output logic [AW-1:0]   addr
);
    localparam logic [AW-1:0] OFS1 = AW'(1);
    localparam logic [AW-1:0] OFS2 = AW'(2);
    localparam logic [AW-1:0] OFS3 = AW'(3);

    always_comb begin
        req  = 1'b1;
        we   = 1'b0;
        addr = tos;
        unique case (state)
            ST_IDLE, ST_POP: begin
                req  = 1'b0;
            end
            ST_CP_RHI: addr = tos - OFS1;
            ST_CP_RLO: addr = tos;
            ST_CP_WHI: begin we = 1'b1; addr = tos + OFS1; end
            ST_CP_WLO: begin we = 1'b1; addr = tos + OFS2; end
            ST_SW_RBH: addr = tos - OFS1;
            ST_SW_RBL: addr = tos;
            ST_SW_RAH: addr = tos - OFS3;
            ST_SW_RAL: addr = tos - OFS2;
            ST_SW_W0:  begin we = 1'b1; addr = tos - OFS3; end
            ST_SW_W1:  begin we = 1'b1; addr = tos - OFS2; end
            ST_SW_W2:  begin we = 1'b1; addr = tos - OFS1; end
            ST_SW_W3:  begin we = 1'b1; addr = tos; end
            default:   req = 1'b0;
        endcase
    end

endmodule

// File: rtl/stkop_hold.sv
module stkop_hold #(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         cap_en,
    input  logic [W-1:0]         din,
    output logic [N-1:0][W-1:0]  held
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held[g] <= '0;
            end else if (cap_en[g]) begin
                held[g] <= din;
            end
        end
    end

endmodule

// File: rtl/stkop_unit.sv
module stkop_unit
    import stkop_pkg::*;
#(
    parameter int             AW         = 16,
    parameter int             CW         = 8,
    parameter logic [AW-1:0]  TOS_RESET  = '1,
    parameter logic [CW-1:0]  FREE_RESET = CW'(64)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [7:0]          op_code,
    output logic                op_ready,
    output logic                done,
    output logic                ovf_err,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic [AW-1:0]       tos,
    output logic [CW-1:0]       free_cells
);
    localparam int            NHOLD  = 4;
    localparam logic [AW-1:0] CELL_W = AW'(2);
    localparam logic [CW-1:0] ONE_C  = CW'(1);

    stk_state_e          state, nxt;
    logic [AW-1:0]       tos_q, tos_n;
    logic [CW-1:0]       free_q, free_n;
    logic                done_q, done_n, err_q, err_n;
    logic [NHOLD-1:0]    cap_en;
    logic [NHOLD-1:0][WORD_W-1:0] held;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            tos_q  <= TOS_RESET;
            free_q <= FREE_RESET;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            state  <= nxt;
            tos_q  <= tos_n;
            free_q <= free_n;
            done_q <= done_n;
            err_q  <= err_n;
        end
    end

    // transitions
    always_comb begin
        nxt    = state;
        tos_n  = tos_q;
        free_n = free_q;
        done_n = 1'b0;
        err_n  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (op_valid) begin
                    case (op_code)
                        OPC_COPY: begin
                            if (free_q == '0) err_n = 1'b1;
                            else              nxt   = ST_CP_RHI;
                        end
                        OPC_POP:  nxt = ST_POP;
                        OPC_SWAP: nxt = ST_SW_RBH;
                        default:  nxt = ST_IDLE;
                    endcase
                end
            end
            ST_POP: begin
                tos_n  = tos_q - CELL_W;
                free_n = free_q + ONE_C;
                done_n = 1'b1;
                nxt    = ST_IDLE;
            end
            ST_CP_RHI: nxt = ST_CP_RLO;
            ST_CP_RLO: nxt = ST_CP_WHI;
            ST_CP_WHI: nxt = ST_CP_WLO;
            ST_CP_WLO: begin
                tos_n  = tos_q + CELL_W;
                free_n = free_q - ONE_C;
                done_n = 1'b1;
                nxt    = ST_IDLE;
            end
            ST_SW_RBH: nxt = ST_SW_RBL;
            ST_SW_RBL: nxt = ST_SW_RAH;
            ST_SW_RAH: nxt = ST_SW_RAL;
            ST_SW_RAL: nxt = ST_SW_W0;
            ST_SW_W0:  nxt = ST_SW_W1;
            ST_SW_W1:  nxt = ST_SW_W2;
            ST_SW_W2:  nxt = ST_SW_W3;
            ST_SW_W3: begin
                done_n = 1'b1;
                nxt    = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs: capture strobes and store data
    always_comb begin
        cap_en    = '0;
        mem_wdata = '0;
        unique case (state)
            ST_CP_RLO: cap_en[0] = 1'b1;
            ST_CP_WHI: begin cap_en[1] = 1'b1; mem_wdata = held[0]; end
            ST_CP_WLO: mem_wdata = held[1];
            ST_SW_RBL: cap_en[0] = 1'b1;
            ST_SW_RAH: cap_en[1] = 1'b1;
            ST_SW_RAL: cap_en[2] = 1'b1;
            ST_SW_W0:  begin cap_en[3] = 1'b1; mem_wdata = held[0]; end
            ST_SW_W1:  mem_wdata = held[1];
            ST_SW_W2:  mem_wdata = held[2];
            ST_SW_W3:  mem_wdata = held[3];
            default:   cap_en = '0;
        endcase
    end

    stkop_agen #(.AW(AW)) u_agen (
        .state (state),
        .tos   (tos_q),
        .req   (mem_req),
        .we    (mem_we),
        .addr  (mem_addr)
    );

    stkop_hold #(.W(WORD_W), .N(NHOLD)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .din    (mem_rdata),
        .held   (held)
    );

    assign op_ready   = (state == ST_IDLE);
    assign done       = done_q;
    assign ovf_err    = err_q;
    assign tos        = tos_q;
    assign free_cells = free_q;

    assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POP) |=> (tos == $past(tos) - CELL_W) && (free_cells == $past(free_cells) + ONE_C));

    assert_copy_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CP_WLO) |=> (tos == $past(tos) + CELL_W) && (free_cells == $past(free_cells) - ONE_C));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ready && op_valid && op_code == OPC_COPY && free_cells == '0)
        |=> (ovf_err && !done && !mem_req && $stable(tos) && $stable(free_cells)));

    assert_swap_keeps_tos_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_POP && state != ST_CP_WLO) |=> $stable(tos));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready |-> !mem_req);

    assert_swap_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ready && op_valid && op_code == OPC_SWAP) |=> (mem_req && !mem_we && mem_addr == $past(tos) - AW'(1)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/sim_stkop_unit.sv
module sim_stkop_unit;
    localparam int AW = 8;
    localparam int CW = 4;
    localparam logic [AW-1:0] TOS0  = 8'h11;
    localparam logic [CW-1:0] FREE0 = 4'd2;

    logic clk = 1'b0;
    logic rst_n;
    logic op_valid;
    logic [7:0] op_code;
    logic op_ready, done, ovf_err, mem_req, mem_we;
    logic [AW-1:0] mem_addr, tos;
    logic [15:0] mem_wdata, mem_rdata;
    logic [CW-1:0] free_cells;

    always #5 clk = ~clk;

    stkop_unit #(.AW(AW), .CW(CW), .TOS_RESET(TOS0), .FREE_RESET(FREE0)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_ready(op_ready), .done(done), .ovf_err(ovf_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tos(tos), .free_cells(free_cells)
    );

    // memory model: one port, read data one cycle after fetch
    logic [15:0] mem [256];
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'hA000 + 16'(i * 37);
        mem_rdata = '0;
    end
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    typedef struct packed { logic we; logic [AW-1:0] addr; logic [15:0] data; } acc_t;
    typedef struct packed { logic err; logic [AW-1:0] t; logic [CW-1:0] f; } res_t;
    acc_t  acc_q[$];
    string atag_q[$];
    res_t  res_q[$];
    string rtag_q[$];

    logic [AW-1:0] m_tos;
    logic [CW-1:0] m_free;
    int done_exp = 0;
    int done_seen = 0;
    bit prev_done = 0;

    task automatic push_acc(input logic we, input logic [AW-1:0] a, input logic [15:0] d, input string tag);
        acc_q.push_back('{we: we, addr: a, data: d});
        atag_q.push_back(tag);
    endtask

    // driver: predicts accesses and results, then performs the handshake
    task automatic run_op(input logic [7:0] code);
        bit busy;
        busy = 1'b0;
        if (code == 8'h64) begin // R8 COPY
            if (m_free == '0) begin
                res_q.push_back('{err: 1'b1, t: m_tos, f: m_free});
                rtag_q.push_back("R5");
            end else begin
                busy = 1'b1;
                push_acc(1'b0, m_tos - 8'd1, '0, "R4");
                push_acc(1'b0, m_tos,        '0, "R4");
                push_acc(1'b1, m_tos + 8'd1, mem[m_tos - 8'd1], "R4");
                push_acc(1'b1, m_tos + 8'd2, mem[m_tos], "R4");
                m_tos = m_tos + 8'd2;
                m_free = m_free - 4'd1;
                res_q.push_back('{err: 1'b0, t: m_tos, f: m_free});
                rtag_q.push_back("R4");
                done_exp++;
            end
        end else if (code == 8'hBF) begin // R8 POP
            busy = 1'b1;
            m_tos = m_tos - 8'd2;
            m_free = m_free + 4'd1;
            res_q.push_back('{err: 1'b0, t: m_tos, f: m_free});
            rtag_q.push_back("R3");
            done_exp++;
        end else if (code == 8'hFD) begin // R8 SWAP
            busy = 1'b1;
            push_acc(1'b0, m_tos - 8'd1, '0, "R6");
            push_acc(1'b0, m_tos,        '0, "R6");
            push_acc(1'b0, m_tos - 8'd3, '0, "R6");
            push_acc(1'b0, m_tos - 8'd2, '0, "R6");
            push_acc(1'b1, m_tos - 8'd3, mem[m_tos - 8'd1], "R6");
            push_acc(1'b1, m_tos - 8'd2, mem[m_tos], "R6");
            push_acc(1'b1, m_tos - 8'd1, mem[m_tos - 8'd3], "R6");
            push_acc(1'b1, m_tos,        mem[m_tos - 8'd2], "R6");
            res_q.push_back('{err: 1'b0, t: m_tos, f: m_free});
            rtag_q.push_back("R6");
            done_exp++;
        end
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = code;
        @(negedge clk);
        if (busy) chk(op_ready == 1'b0, "R2", "ready while busy", 32'(op_ready), 32'd0);
        op_code = 8'hBF; // held valid while busy: must not be taken
        while (!op_ready) @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
    endtask

    // monitor: compares accesses and results as they appear
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (mem_req) begin
                if (acc_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected access", 32'(mem_addr), 32'hFFFF_FFFF);
                end else begin
                    acc_t e;
                    string tg;
                    e = acc_q.pop_front();
                    tg = atag_q.pop_front();
                    chk(mem_we == e.we, tg, "access kind", 32'(mem_we), 32'(e.we));
                    chk(mem_addr == e.addr, tg, "access address", 32'(mem_addr), 32'(e.addr));
                    if (e.we) chk(mem_wdata == e.data, tg, "store data", 32'(mem_wdata), 32'(e.data));
                end
            end
            if (done) done_seen++;
            if (done && prev_done) chk(1'b0, "R9", "done wider than one cycle", 32'd1, 32'd0);
            prev_done = done;
            if (done || ovf_err) begin
                if (res_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected completion", {30'd0, done, ovf_err}, 32'd0);
                end else begin
                    res_t r;
                    string tg;
                    r = res_q.pop_front();
                    tg = rtag_q.pop_front();
                    chk(ovf_err == r.err, tg, "overflow flag", 32'(ovf_err), 32'(r.err));
                    chk(done == !r.err, tg, "done flag", 32'(done), 32'(!r.err));
                    chk(tos == r.t, tg, "tos", 32'(tos), 32'(r.t));
                    chk(free_cells == r.f, tg, "free_cells", 32'(free_cells), 32'(r.f));
                end
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        op_valid = 1'b0;
        op_code = 8'h00;
        m_tos = TOS0;
        m_free = FREE0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(op_ready == 1'b1, "R1", "op_ready", 32'(op_ready), 32'd1);
        chk(done == 1'b0, "R1", "done", 32'(done), 32'd0);
        chk(ovf_err == 1'b0, "R1", "ovf_err", 32'(ovf_err), 32'd0);
        chk(mem_req == 1'b0, "R1", "mem_req", 32'(mem_req), 32'd0);
        chk(tos == TOS0, "R1", "tos", 32'(tos), 32'(TOS0));
        chk(free_cells == FREE0, "R1", "free_cells", 32'(free_cells), 32'(FREE0));

        run_op(8'hFD);   // R6 swap on preloaded stack
        run_op(8'h64);   // R4 copy
        run_op(8'h64);   // R4 copy fills free space
        run_op(8'h64);   // R5 overflow
        run_op(8'h00);   // R2 unknown code
        repeat (5) @(negedge clk);
        chk(tos == m_tos, "R2", "tos after unknown code", 32'(tos), 32'(m_tos));
        chk(free_cells == m_free, "R2", "free after unknown code", 32'(free_cells), 32'(m_free));
        run_op(8'hBF);   // R3 pop
        run_op(8'hBF);   // R3 pop again
        run_op(8'hFD);   // R6 swap at moved pointer
        run_op(8'h64);   // R4 copy after pops
        repeat (4) @(negedge clk);

        chk(acc_q.size() == 0, "R7", "accesses left over", 32'(acc_q.size()), 32'd0);
        chk(res_q.size() == 0, "R9", "results left over", 32'(res_q.size()), 32'd0);
        chk(done_seen == done_exp, "R9", "done pulse count", 32'(done_seen), 32'(done_exp));
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule